// File: doc/BRIEF.md
# Sequential Multiply Coprocessor with Start/Done Handshake

This block is an execution unit attached to a processor. It takes two operands and returns the low half of their product several clock cycles later. The processor raises `start` for one cycle to issue an operation, with both operands present in that cycle. It then waits for `done` and samples `result` on the clock edge where `done` is high. The multiply uses shift-and-add, one multiplier bit per enabled clock.

Every state change is qualified by `clkEn`. While the qualifier is low the unit ignores the clock and holds all of its state, so the latency is counted in enabled edges only. `rst` is synchronous and active high, and it acts whatever the level of `clkEn`.

Top module: `seqmul_unit`

## Requirements
- R1: A clock edge with `rst` high sets `done` and `result` to zero and returns the unit to idle, even in the middle of an operation.
- R2: When `start` and `clkEn` are both high at an edge while the unit is idle, that edge is the start edge. `done` goes high after the 32nd enabled edge that follows it, so the processor samples it on the 33rd enabled edge after the start edge.
- R3: While `done` is high, `result` equals the low `DATA_W` bits of `opA * opB`, with both operands taken at the start edge.
- R4: `done` stays high for exactly one enabled edge. The unit accepts a new start at the first enabled edge after `done` has fallen, so operations can run back to back.
- R5: A `start` seen while an operation is running, including the cycle in which `done` is high, is ignored. It produces no extra `done`.
- R6: While `clkEn` is low, `done`, `result` and the iteration progress hold. A `start` with `clkEn` low is not accepted.
- R7: `result` changes only when `done` rises. Between operations it keeps the last product.
- R8: Changes on `opA` and `opB` after the start edge have no effect on the product returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clkEn | input | 1 | Clock qualifier; while low, all state holds |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe, high for the first cycle of an operation |
| opA | input | DATA_W | Multiplicand, valid with `start` |
| opB | input | DATA_W | Multiplier, valid with `start` |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Low half of the product, valid while `done` is high |

## Verification
The hardest condition to reach from the ports is an operation whose enabled edges are scattered among stalled cycles. Such a run must still finish on exactly the 33rd enabled edge and must not move while stalled. The bench drives `clkEn` from a pseudo-random sequence during a block of operations and counts enabled edges itself to get the expected completion edge. It also issues stray `start` pulses in mid-run, in the `done` cycle and with `clkEn` low. It then watches for any completion that no accepted start accounts for.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

  // Per-cycle strobes from control to datapath; all already qualified by clkEn.
  typedef struct packed {
    logic load;    // capture operands, clear accumulator
    logic step;    // one shift-and-add iteration
    logic finish;  // last iteration: latch the product into the result register
  } mulCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mulState_t;

endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
  import seqmul_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic     clk,
  input  logic     clkEn,
  input  logic     rst,
  input  logic     start,
  output mulCtrl_t ctrl,
  output logic     done
);
  localparam int CW = (ITER > 2) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  mulState_t      state;
  logic [CW-1:0]  iterCnt;
  logic           lastIter;

  assign lastIter = (iterCnt == LAST);

  always_comb begin
    ctrl = '0;
    if (clkEn) begin
      unique case (state)
        ST_IDLE: ctrl.load = start;
        ST_RUN: begin
          ctrl.step   = 1'b1;
          ctrl.finish = lastIter;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else if (clkEn) begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (lastIter) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          done  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath
  import seqmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  mulCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] mcand;
  logic [DATA_W-1:0] mplier;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] accNext;

  // Partial product of the current multiplier bit folded into the running sum.
  assign accNext = mplier[0] ? (acc + mcand) : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      result <= '0;
    end else begin
      if (ctrl.load) begin
        mcand  <= opA;
        mplier <= opB;
        acc    <= '0;
      end
      if (ctrl.step) begin
        acc    <= accNext;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
      end
      if (ctrl.finish) begin
        result <= accNext;
      end
    end
  end

endmodule

// File: rtl/seqmul_unit.sv
module seqmul_unit
  import seqmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              clkEn,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  mulCtrl_t ctrl;

  seqmul_ctrl #(.ITER(DATA_W)) uCtrl (
    .clk   (clk),
    .clkEn (clkEn),
    .rst   (rst),
    .start (start),
    .ctrl  (ctrl),
    .done  (done)
  );

  seqmul_datapath #(.DATA_W(DATA_W)) uPath (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/seqmul_unit_chk.sv
module seqmul_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              clkEn,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic [DATA_W-1:0] result
);
  localparam int KW = $clog2(DATA_W) + 1;
  localparam logic [KW-1:0] DUE = KW'(DATA_W);

  // Independent model of the operation window: enabled edges since the accepted start.
  logic          pend;
  logic [KW-1:0] edgeCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      edgeCnt <= '0;
    end else if (clkEn) begin
      if (!pend && start) begin
        pend    <= 1'b1;
        edgeCnt <= '0;
      end else if (pend) begin
        if (done) pend <= 1'b0;
        else      edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && result == '0));

  assert_done_only_when_due_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (pend && edgeCnt == DUE));

  assert_done_when_due_R2: assert property (@(posedge clk) disable iff (rst)
    (pend && edgeCnt == DUE) |-> done);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    (done && clkEn) |=> !done);

  assert_hold_when_stalled_R6: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> ($stable(done) && $stable(result)));

  assert_result_moves_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

endmodule

bind seqmul_unit seqmul_unit_chk #(.DATA_W(DATA_W)) uChk (
  .clk    (clk),
  .clkEn  (clkEn),
  .rst    (rst),
  .start  (start),
  .done   (done),
  .result (result)
);

// File: tb/sim_seqmul_unit.sv
module sim_seqmul_unit;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         clkEn = 1'b1;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         done;
  logic [W-1:0] result;

  seqmul_unit #(.DATA_W(W)) u0 (
    .clk(clk), .clkEn(clkEn), .rst(rst), .start(start),
    .opA(opA), .opB(opB), .done(done), .result(result)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [W-1:0] prod;
    int           edgeIdx;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int fails = 0;
  int enCount = 0;
  int ceMode = 0;
  bit lastEn = 1'b1;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Enabled-edge counter kept by the bench itself.
  always @(posedge clk) begin
    lastEn = clkEn;
    if (clkEn) enCount++;
  end

  // Clock-qualifier generator: 0 = always on, 1 = pseudo-random gaps, 2 = off.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ceMode)
      0: clkEn = 1'b1;
      1: clkEn = lfsr[0] | lfsr[3];
      default: clkEn = 1'b0;
    endcase
  end

  // Monitor: pops the scoreboard on each rising done, checks hold and result stability.
  logic         prevDone = 1'b0;
  logic [W-1:0] prevRes = '0;
  bit           prevRst = 1'b1;
  bit           doneSeen = 1'b0;

  always @(negedge clk) begin
    exp_t e;
    #1;
    if (rst || prevRst) begin
      doneSeen = 1'b0;
    end else begin
      if (!lastEn)
        check(done == prevDone && result == prevRes, "R6 state held while stalled", result, prevRes);
      if (result != prevRes)
        check(done && !prevDone, "R7 result changed only as done rose", result, prevRes);
      if (done && !doneSeen) begin
        doneSeen = 1'b1;
        if (sb.size() == 0) begin
          check(1'b0, "R5 done with no accepted start", result, '0);
        end else begin
          e = sb.pop_front();
          check(result == e.prod, "R3 product low half", result, e.prod);
          check(enCount == e.edgeIdx + W, "R2 completion edge", W'(enCount), W'(e.edgeIdx + W));
        end
      end else if (!done) begin
        doneSeen = 1'b0;
      end
    end
    prevDone = done;
    prevRes  = result;
    prevRst  = rst;
  end

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  // Driver: called at negedge+0.5; issues when the qualifier is high, then scrambles operands (R8).
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    while (!clkEn) step();
    opA = a;
    opB = b;
    start = 1'b1;
    e.prod = a * b;
    e.edgeIdx = enCount + 1;
    sb.push_back(e);
    step();
    start = 1'b0;
    opA = ~a;
    opB = b ^ 32'h5A5A_0F0F;
  endtask

  task automatic waitIdle();
    while (sb.size() != 0 || done) step();
  endtask

  initial begin
    logic [W-1:0] keep;
    rst = 1'b1;
    repeat (3) step();
    check(done == 1'b0, "R1 done cleared by reset", W'(done), '0);
    check(result == '0, "R1 result cleared by reset", result, '0);
    rst = 1'b0;
    step();

    // Back-to-back operations with the qualifier always on (R2, R3, R4, R8).
    issue(32'd3, 32'd5);                 waitIdle();
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF); waitIdle();
    issue(32'h0, 32'hDEAD_BEEF);         waitIdle();
    issue(32'h1234_5678, 32'h9ABC_DEF0); waitIdle();
    issue(32'h8000_0000, 32'd2);         waitIdle();
    issue(32'h0000_FFFF, 32'h0000_FFFF); waitIdle();
    issue(32'd7, 32'd1);                 waitIdle();

    // Stray starts mid-run and in the done cycle (R5).
    issue(32'd1000, 32'd3000);
    repeat (7) step();
    start = 1'b1; opA = 32'hFFFF_0000; opB = 32'h0000_FFFF;
    step();
    start = 1'b0;
    while (!done) step();
    start = 1'b1; opA = 32'd9; opB = 32'd9;
    step();
    start = 1'b0;
    waitIdle();
    repeat (45) step();
    check(done == 1'b0, "R5 no done from ignored starts", W'(done), '0);
    check(result == 32'd3000000, "R5 result kept after ignored starts", result, 32'd3000000);

    // Pseudo-random qualifier gaps (R2, R6).
    ceMode = 1;
    issue(32'hCAFE_F00D, 32'h0BAD_BEEF); waitIdle();
    issue(32'd12345, 32'd6789);          waitIdle();
    issue(32'hFFFF_FFFF, 32'd2);         waitIdle();
    issue(32'h1357_9BDF, 32'h2468_ACE0); waitIdle();
    ceMode = 0;
    step();

    // Start with the qualifier low is not accepted (R6).
    keep = result;
    ceMode = 2;
    step(); step();
    start = 1'b1; opA = 32'd11; opB = 32'd13;
    repeat (4) step();
    start = 1'b0;
    ceMode = 0;
    repeat (50) step();
    check(done == 1'b0, "R6 stalled start produced no done", W'(done), '0);
    check(result == keep, "R6 result unchanged by stalled start", result, keep);

    // Reset in the middle of an operation (R1), then normal function again.
    issue(32'd77, 32'd88);
    repeat (10) step();
    rst = 1'b1;
    sb.delete();
    step(); step();
    check(done == 1'b0, "R1 done cleared mid-operation", W'(done), '0);
    check(result == '0, "R1 result cleared mid-operation", result, '0);
    rst = 1'b0;
    step();
    repeat (40) step();
    check(done == 1'b0, "R1 aborted operation never completes", W'(done), '0);
    issue(32'd21, 32'd2); waitIdle();
    step();
    check(result == 32'd42, "R4 unit usable after reset", result, 32'd42);

    check(sb.size() == 0, "R2 every accepted start completed", W'(sb.size()), '0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired R2 actual=%0d expected=%0d", sb.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule